// File: doc/BRIEF.md
# Two-Player Dice Game Controller

This block runs a turn-based dice game for two players. A die counter runs from 1 to 6 and steps on every clock for as long as the roll button is held, so the value left when the button is released acts as the throw. The current player keeps rolling and builds up a turn sum. If the throw is a one, the turn sum is lost and play passes to the other player. If the player presses hold, the turn sum is banked into that player's total. Once a banked total reaches the winning score, the game stops and the winner's lamp blinks until a new game is requested.

The roll, hold and new-game buttons pass through a small synchronizer before the state machine uses them. Hold and new-game act on their rising edge. The die value, the turn sum, both totals and the two lamps all come straight from registers. The blink rate comes from a clock-enable divider whose period is a parameter.

Top module: `dice_game_ctrl`

## Requirements
- R1: The die output is 1 after reset. It advances once for each clock in which the synchronized roll input is high (6 is followed by 1, any other value by value+1), and it only ever holds 1 through 6.
- R2: After reset both totals and the turn sum are 0, player 1 is current and is the first player, lamp1_o is 1 and lamp2_o is 0.
- R3: When a roll ends with the die showing 1, the turn sum becomes 0 and the other player becomes current.
- R4: When a roll ends with the die showing 2 to 6, the die value is added to the turn sum, saturating at 127, and the same player stays current.
- R5: A rising edge of hold while idle adds the turn sum to the current player's total, saturating at 127, and clears the turn sum. If the new total is below WIN_SCORE (100), the other player becomes current.
- R6: If a total is WIN_SCORE or more after a hold, the game enters the win state. In that state roll and hold have no effect: the die, the turn sum and both totals stay unchanged.
- R7: Outside the win state, lamp1_o is 1 exactly when player 1 is current and lamp2_o is 1 exactly when player 2 is current. The two lamps are never lit together.
- R8: In the win state the winner's lamp toggles every BLINK_DIV clocks and the other lamp stays 0.
- R9: A rising edge of new-game in the win state clears both totals and the turn sum, swaps the first player, and makes the new first player current. Outside the win state, new-game has no effect.
- R10: A hold edge that arrives while a roll is in progress is ignored. Releasing the roll while hold is still held does not bank the turn sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| roll_i | input | 1 | Roll button, level; the die runs while it is high |
| hold_i | input | 1 | Hold button; acts on its rising edge |
| newgame_i | input | 1 | New-game button; acts on its rising edge in the win state |
| die_o | output | 3 | Die value, 1 to 6 |
| turn_sum_o | output | SCORE_W | Turn sum of the current player |
| total1_o | output | SCORE_W | Player 1 total |
| total2_o | output | SCORE_W | Player 2 total |
| lamp1_o | output | 1 | Player 1 lamp (current player, or blinking winner) |
| lamp2_o | output | 1 | Player 2 lamp (current player, or blinking winner) |

## Verification
The assertions assume the buttons come from a person. The level on roll is expected to drop back to idle before another action starts, so each turn-sum increase comes from a single throw of at most 6. Hold and new-game pulses are expected to be spaced far enough apart that the game is idle or in the win state when they arrive.

The stimulus follows these assumptions. It holds each button for a known number of clocks and then waits for several idle clocks. Because the bench controls how many clocks roll is high, it can predict the die value exactly. It uses this to choose throw lengths that force a one, force a six, or push the turn sum into saturation.

// File: rtl/dice_game_pkg.sv
package dice_game_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROLL,
    ST_EVAL,
    ST_COMMIT,
    ST_TEST,
    ST_WIN
  } game_st_e;

  localparam int DIE_W   = 3;
  localparam int DIE_MAX = 6;
endpackage

// File: rtl/dg_sync.sv
module dg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg_q[s] <= '0;
          else     stg_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg_q[s] <= '0;
          else     stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dg_die.sv
module dg_die
  import dice_game_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  output logic [DIE_W-1:0] die_o
);
  always_ff @(posedge clk) begin
    if (rst)
      die_o <= DIE_W'(1);
    else if (adv_i)
      die_o <= (die_o == DIE_W'(DIE_MAX)) ? DIE_W'(1) : die_o + DIE_W'(1);
  end
endmodule

// File: rtl/dg_blink.sv
module dg_blink #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic phase_o
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_o <= 1'b1;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + CNT_W'(1);
      if (tick) phase_o <= ~phase_o;
    end
  end
endmodule

// File: rtl/dg_score_bank.sv
module dg_score_bank #(
  parameter int W       = 7,
  parameter int PLAYERS = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr_i,
  input  logic                        add_en_i,
  input  logic [SEL_W-1:0]            sel_i,
  input  logic [W-1:0]                add_val_i,
  output logic [PLAYERS-1:0][W-1:0]   totals_o
);
  localparam int SEL_W = (PLAYERS > 1) ? $clog2(PLAYERS) : 1;

  generate
    for (genvar p = 0; p < PLAYERS; p++) begin : g_player
      logic [W:0] sum;
      assign sum = {1'b0, totals_o[p]} + {1'b0, add_val_i};
      always_ff @(posedge clk) begin
        if (rst || clr_i)
          totals_o[p] <= '0;
        else if (add_en_i && sel_i == SEL_W'(p))
          totals_o[p] <= sum[W] ? {W{1'b1}} : sum[W-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/dice_game_ctrl.sv
module dice_game_ctrl
  import dice_game_pkg::*;
#(
  parameter int SCORE_W     = 7,
  parameter int WIN_SCORE   = 100,
  parameter int BLINK_DIV   = 25_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               roll_i,
  input  logic               hold_i,
  input  logic               newgame_i,
  output logic [2:0]         die_o,
  output logic [SCORE_W-1:0] turn_sum_o,
  output logic [SCORE_W-1:0] total1_o,
  output logic [SCORE_W-1:0] total2_o,
  output logic               lamp1_o,
  output logic               lamp2_o
);
  localparam int SW1 = SCORE_W + 1;
  localparam logic [SCORE_W-1:0] WIN_LIM = SCORE_W'(WIN_SCORE);

  logic [2:0]                 btn_s;
  logic                       roll_s, hold_s, ng_s;
  logic                       hold_q, ng_q;
  logic                       hold_rise, ng_rise;
  game_st_e                   state_q, state_d;
  logic                       cur_q, first_q;
  logic [SCORE_W-1:0]         turn_q;
  logic [1:0][SCORE_W-1:0]    totals;
  logic [SCORE_W-1:0]         cur_total;
  logic [SW1-1:0]             turn_add;
  logic                       die_adv, die_is_one;
  logic                       blink;
  logic                       restart;
  logic                       win_flag;

  dg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({newgame_i, hold_i, roll_i}),
    .q_o (btn_s)
  );

  assign roll_s = btn_s[0];
  assign hold_s = btn_s[1];
  assign ng_s   = btn_s[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      ng_q   <= 1'b0;
    end else begin
      hold_q <= hold_s;
      ng_q   <= ng_s;
    end
  end

  assign hold_rise = hold_s & ~hold_q;
  assign ng_rise   = ng_s & ~ng_q;

  assign die_adv = roll_s && (state_q == ST_IDLE || state_q == ST_ROLL);

  dg_die u_die (
    .clk   (clk),
    .rst   (rst),
    .adv_i (die_adv),
    .die_o (die_o)
  );

  dg_blink #(.DIV(BLINK_DIV)) u_blink (
    .clk     (clk),
    .rst     (rst),
    .phase_o (blink)
  );

  assign restart = (state_q == ST_WIN) && ng_rise;

  dg_score_bank #(.W(SCORE_W), .PLAYERS(2)) u_scores (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (restart),
    .add_en_i  (state_q == ST_COMMIT),
    .sel_i     (cur_q),
    .add_val_i (turn_q),
    .totals_o  (totals)
  );

  assign cur_total  = totals[cur_q];
  assign die_is_one = (die_o == 3'd1);
  assign turn_add   = {1'b0, turn_q} + SW1'(die_o);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (roll_s)         state_d = ST_ROLL;
        else if (hold_rise) state_d = ST_COMMIT;
      end
      ST_ROLL:   if (!roll_s) state_d = ST_EVAL;
      ST_EVAL:   state_d = ST_IDLE;
      ST_COMMIT: state_d = ST_TEST;
      ST_TEST:   state_d = (cur_total >= WIN_LIM) ? ST_WIN : ST_IDLE;
      ST_WIN:    if (ng_rise) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cur_q   <= 1'b0;
      first_q <= 1'b0;
      turn_q  <= '0;
    end else begin
      state_q <= state_d;
      case (state_q)
        ST_EVAL: begin
          if (die_is_one) begin
            turn_q <= '0;
            cur_q  <= ~cur_q;
          end else begin
            turn_q <= turn_add[SCORE_W] ? {SCORE_W{1'b1}} : turn_add[SCORE_W-1:0];
          end
        end
        ST_COMMIT: turn_q <= '0;
        ST_TEST:   if (cur_total < WIN_LIM) cur_q <= ~cur_q;
        ST_WIN: begin
          if (ng_rise) begin
            first_q <= ~first_q;
            cur_q   <= ~first_q;
            turn_q  <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lamp1_o <= 1'b1;
      lamp2_o <= 1'b0;
    end else if (state_q == ST_WIN) begin
      lamp1_o <= ~cur_q & blink;
      lamp2_o <= cur_q & blink;
    end else begin
      lamp1_o <= ~cur_q;
      lamp2_o <= cur_q;
    end
  end

  assign win_flag   = (state_q == ST_WIN);
  assign turn_sum_o = turn_q;
  assign total1_o   = totals[0];
  assign total2_o   = totals[1];
endmodule

// File: rtl/dice_game_chk.sv
module dice_game_chk #(
  parameter int SCORE_W = 7
) (
  input logic               clk,
  input logic               rst,
  input logic [2:0]         die_o,
  input logic [SCORE_W-1:0] turn_sum_o,
  input logic [SCORE_W-1:0] total1_o,
  input logic [SCORE_W-1:0] total2_o,
  input logic               lamp1_o,
  input logic               lamp2_o,
  input logic               in_win
);
  AST_DIE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (die_o >= 3'd1 && die_o <= 3'd6)); // R1

  AST_DIE_STEP: assert property (@(posedge clk) disable iff (rst)
    (die_o != $past(die_o)) |->
      (die_o == (($past(die_o) == 3'd6) ? 3'd1 : $past(die_o) + 3'd1))); // R1

  AST_TURN_STEP: assert property (@(posedge clk) disable iff (rst)
    (turn_sum_o > $past(turn_sum_o)) |->
      ((turn_sum_o - $past(turn_sum_o)) <= SCORE_W'(6))); // R4

  AST_TOTAL_DROP: assert property (@(posedge clk) disable iff (rst)
    ((total1_o < $past(total1_o)) || (total2_o < $past(total2_o))) |->
      $past(in_win)); // R9

  AST_WIN_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ($past(in_win) && in_win) |->
      ($stable(total1_o) && $stable(total2_o) && $stable(die_o) && $stable(turn_sum_o))); // R6

  AST_LAMP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(lamp1_o && lamp2_o)); // R7
endmodule

bind dice_game_ctrl dice_game_chk #(.SCORE_W(SCORE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .die_o      (die_o),
  .turn_sum_o (turn_sum_o),
  .total1_o   (total1_o),
  .total2_o   (total2_o),
  .lamp1_o    (lamp1_o),
  .lamp2_o    (lamp2_o),
  .in_win     (win_flag)
);

// File: tb/dice_game_ctrl_bench.sv
module dice_game_ctrl_bench;
  localparam int SW  = 7;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic roll_i = 1'b0, hold_i = 1'b0, newgame_i = 1'b0;
  logic [2:0]    die_o;
  logic [SW-1:0] turn_sum_o, total1_o, total2_o;
  logic          lamp1_o, lamp2_o;

  int n_tests = 0;
  int n_fail  = 0;
  int m_die, m_turn, m_cur, m_first, m_win;
  int m_tot [2];

  always #4 clk = ~clk;

  dice_game_ctrl #(.SCORE_W(SW), .WIN_SCORE(100), .BLINK_DIV(DIV), .SYNC_STAGES(2))
    u_dice_game_ctrl (
    .clk(clk), .rst(rst), .roll_i(roll_i), .hold_i(hold_i), .newgame_i(newgame_i),
    .die_o(die_o), .turn_sum_o(turn_sum_o), .total1_o(total1_o), .total2_o(total2_o),
    .lamp1_o(lamp1_o), .lamp2_o(lamp2_o)
  );

  function automatic int next_die(int d, int n);
    int r = d;
    for (int i = 0; i < n; i++) r = (r == 6) ? 1 : r + 1;
    return r;
  endfunction

  function automatic int sat(int a, int b);
    return (a + b > 127) ? 127 : a + b;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "die", int'(die_o), m_die);
    chk(req, "turn", int'(turn_sum_o), m_turn);
    chk(req, "total1", int'(total1_o), m_tot[0]);
    chk(req, "total2", int'(total2_o), m_tot[1]);
    if (m_win == 0) begin
      chk(req, "lamp1", int'(lamp1_o), (m_cur == 0) ? 1 : 0);
      chk(req, "lamp2", int'(lamp2_o), (m_cur == 1) ? 1 : 0);
    end else begin
      chk(req, "loser lamp", (m_cur == 0) ? int'(lamp2_o) : int'(lamp1_o), 0);
    end
  endtask

  task automatic apply_roll_model(int n);
    if (m_win == 0) begin
      m_die = next_die(m_die, n);
      if (m_die == 1) begin
        m_turn = 0;
        m_cur  = 1 - m_cur;
      end else begin
        m_turn = sat(m_turn, m_die);
      end
    end
  endtask

  task automatic do_roll(int n);
    roll_i = 1'b1;
    repeat (n) @(negedge clk);
    roll_i = 1'b0;
    repeat (8) @(negedge clk);
    apply_roll_model(n);
  endtask

  task automatic do_hold();
    hold_i = 1'b1;
    repeat (2) @(negedge clk);
    hold_i = 1'b0;
    repeat (8) @(negedge clk);
    if (m_win == 0) begin
      m_tot[m_cur] = sat(m_tot[m_cur], m_turn);
      m_turn = 0;
      if (m_tot[m_cur] >= 100) m_win = 1;
      else m_cur = 1 - m_cur;
    end
  endtask

  task automatic do_newgame();
    newgame_i = 1'b1;
    repeat (2) @(negedge clk);
    newgame_i = 1'b0;
    repeat (8) @(negedge clk);
    if (m_win != 0) begin
      m_first = 1 - m_first;
      m_cur   = m_first;
      m_tot[0] = 0;
      m_tot[1] = 0;
      m_turn  = 0;
      m_win   = 0;
    end
  endtask

  task automatic check_blink();
    int prev, toggles, loser_lit, w;
    toggles = 0;
    loser_lit = 0;
    prev = (m_cur == 0) ? int'(lamp1_o) : int'(lamp2_o);
    for (int i = 0; i < 8 * DIV; i++) begin
      @(negedge clk);
      w = (m_cur == 0) ? int'(lamp1_o) : int'(lamp2_o);
      if (w != prev) toggles++;
      prev = w;
      if (((m_cur == 0) ? lamp2_o : lamp1_o) == 1'b1) loser_lit++;
    end
    chk("R8", "blink toggles in range", (toggles >= 7 && toggles <= 8) ? 1 : 0, 1);
    chk("R8", "loser lamp lit count", loser_lit, 0);
  endtask

  // roll length that leaves the die at the wanted face
  function automatic int len_to(int from, int face);
    int n = (face - from + 6) % 6;
    return (n == 0) ? 6 : n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_die = 1; m_turn = 0; m_cur = 0; m_first = 0; m_win = 0;
    m_tot[0] = 0; m_tot[1] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_all("R2 reset");

    // R1 R4: two clocks of roll -> die 3, turn 3
    do_roll(2);
    check_all("R1 R4 roll to 3");
    // R3: land on one
    do_roll(len_to(m_die, 1));
    chk("R3", "die is one", int'(die_o), 1);
    check_all("R3 one passes turn");
    // R9: new game outside win ignored
    do_newgame();
    check_all("R9 newgame ignored");
    // R10: hold raised during a roll is ignored
    roll_i = 1'b1;
    repeat (4) @(negedge clk);
    hold_i = 1'b1;
    repeat (3) @(negedge clk);
    roll_i = 1'b0;
    repeat (6) @(negedge clk);
    hold_i = 1'b0;
    repeat (8) @(negedge clk);
    apply_roll_model(7);
    check_all("R10 hold during roll");
    // R5: hold banks and passes
    do_roll(len_to(m_die, 5));
    do_hold();
    check_all("R5 hold banks");
    // R4 R5 R6: saturate the turn sum on sixes, then win
    for (int i = 0; i < 25; i++) do_roll(6 - (m_die == 6 ? 0 : 0) + (m_die == 6 ? 0 : len_to(m_die, 6) - 6));
    chk("R4", "turn saturates", int'(turn_sum_o), 127);
    check_all("R4 saturation");
    do_hold();
    chk("R5", "total saturates", (m_cur == 0) ? int'(total1_o) : int'(total2_o), 127);
    check_all("R6 win entered");
    check_blink();
    do_roll(3);
    do_hold();
    check_all("R6 win ignores roll and hold");
    do_newgame();
    check_all("R9 newgame swaps first player");

    // random play
    void'($urandom(32'd1234));
    for (int a = 0; a < 300; a++) begin
      if (m_win != 0) begin
        check_blink();
        do_newgame();
        check_all("R9 random newgame");
      end else if ($urandom_range(0, 9) < 3) begin
        do_hold();
        check_all("R5 random hold");
      end else begin
        do_roll(int'($urandom_range(1, 12)));
        check_all("R1 R3 R4 random roll");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule